// File: doc/BRIEF.md
# Control-Word Sequencer with Next-Address Generator

This block sequences a processor that has no instruction decoder. A program memory stores wide control words. Each clock, the word addressed by the program counter is loaded into a control-word register. The low part of that register drives the datapath directly: one set of raw control bits and a small immediate constant. The upper part is the controller section, and it steers a next-address generator.

The generator compares a one-bit condition field with a registered status bit coming back from the datapath. When the two match and the word enables a jump, the program counter takes a target. That target is either the counter plus a signed offset or an absolute address supplied by the datapath. In every other case the counter steps by one, wrapping at the memory depth. A call flag saves the return address in a link register. The datapath returns from the call by putting the link value back on the address port and jumping with the absolute kind.

Because the control word is registered, the word fetched alongside a taken jump still executes. Every branch therefore has exactly one delay slot.

Top module: `cws_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, `pc`, `dp_ctl`, `const_val` and `link_addr` all become zero after that edge. The all-zero control word never jumps.
- R2: `dp_ctl` and `const_val` show the datapath bits [DP_W-1:0] and the constant bits [DP_W+K_W-1:DP_W] of the word stored at the address `pc` held one cycle earlier. This includes the word after a taken jump, which forms a single delay slot.
- R3: If the jump-enable bit (word bit CW_W-2) of the registered word is 0, `pc` advances by one on the next edge, whatever the condition, offset, status and address inputs are.
- R4: For a taken jump of the relative kind (jump-kind bit CW_W-3 = 0), the next `pc` is `pc` plus the offset field [DP_W+K_W+OFS_W-1:DP_W+K_W], read as two's complement. The sum wraps modulo 2^PC_W, so backward jumps work.
- R5: For a taken jump of the absolute kind (jump-kind bit = 1), the next `pc` equals `addr_in`. This is also how a return is made, by driving `link_addr` onto `addr_in`.
- R6: A jump is taken only when the condition bit (word bit CW_W-4) equals the value `status_in` had at the previous edge. If they differ, `pc` advances by one.
- R7: When the call bit (word bit CW_W-1) is set and the jump is taken, `link_addr` becomes the pre-jump `pc` plus one. In all other cycles `link_addr` keeps its value.
- R8: Sequential stepping from address 2^PC_W-1 wraps to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| status_in | input | 1 | Status bit from the datapath, registered before use |
| addr_in | input | PC_W | Absolute jump target from the datapath |
| dp_ctl | output | DP_W | Datapath control bits of the current word |
| const_val | output | K_W | Immediate constant of the current word |
| pc | output | PC_W | Program counter |
| link_addr | output | PC_W | Return address saved by the last taken call |

## Verification
The bench builds the block with a 32-word program (PC_W=5), 8-bit datapath and constant fields, and a 4-bit offset. With this size, a random walk through the program frequently reaches the wrap from address 31 to 0. The same walk also exercises the -3 backward jump, the call at one address and the return a few words later. The narrow offset puts both signs of the offset within one short loop. A single status bit lets a fair random stream take and skip each conditional word about equally often.

// File: rtl/cws_pkg.sv
package cws_pkg;

  typedef enum logic {
    JK_REL = 1'b0,
    JK_ABS = 1'b1
  } jump_kind_e;

  // Controller section, most significant bits of the control word.
  typedef struct packed {
    logic       call;
    logic       jen;
    jump_kind_e jkind;
    logic       cond;
  } ag_ctl_t;

endpackage

// File: rtl/cws_prog_rom.sv
module cws_prog_rom #(
  parameter int PC_W = 5,
  parameter int CW_W = 24,
  localparam int DEPTH = 1 << PC_W,
  parameter logic [DEPTH*CW_W-1:0] INIT = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] addr,
  output logic [CW_W-1:0] cw_q
);

  logic [CW_W-1:0] rom [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_word
    assign rom[a] = INIT[a*CW_W +: CW_W];
  end

  // Registered read: this register is the control-word register.
  always_ff @(posedge clk) begin
    if (rst) cw_q <= '0;
    else     cw_q <= rom[addr];
  end

  p_cw_clear_r1: assert property (@(posedge clk) rst |=> cw_q == '0);

endmodule

// File: rtl/cws_addr_gen.sv
module cws_addr_gen
  import cws_pkg::*;
#(
  parameter int PC_W  = 5,
  parameter int OFS_W = 4
) (
  input  logic [PC_W-1:0]  pc_cur,
  input  ag_ctl_t          ctl,
  input  logic [OFS_W-1:0] ofs,
  input  logic             status_q,
  input  logic [PC_W-1:0]  addr_in,
  output logic [PC_W-1:0]  next_pc,
  output logic             link_we,
  output logic [PC_W-1:0]  link_val
);

  logic signed [OFS_W-1:0] ofs_s;
  logic [PC_W-1:0] ofs_ext, seq_pc, tgt;
  logic taken;

  assign ofs_s   = ofs;
  assign ofs_ext = PC_W'(ofs_s);
  assign seq_pc  = pc_cur + PC_W'(1);
  assign taken   = ctl.jen && (ctl.cond == status_q);
  assign tgt     = (ctl.jkind == JK_ABS) ? addr_in : pc_cur + ofs_ext;
  assign next_pc = taken ? tgt : seq_pc;
  assign link_we = taken && ctl.call;
  assign link_val = seq_pc;

endmodule

// File: rtl/cws_link_reg.sv
module cws_link_reg #(
  parameter int PC_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [PC_W-1:0] d,
  output logic [PC_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= d;
  end

endmodule

// File: rtl/cws_sequencer.sv
module cws_sequencer
  import cws_pkg::*;
#(
  parameter int PC_W  = 5,
  parameter int DP_W  = 8,
  parameter int K_W   = 8,
  parameter int OFS_W = 4,
  parameter logic [(2**PC_W)*(DP_W+K_W+OFS_W+$bits(ag_ctl_t))-1:0] PROG = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            status_in,
  input  logic [PC_W-1:0] addr_in,
  output logic [DP_W-1:0] dp_ctl,
  output logic [K_W-1:0]  const_val,
  output logic [PC_W-1:0] pc,
  output logic [PC_W-1:0] link_addr
);

  localparam int CTL_W = $bits(ag_ctl_t);
  localparam int CW_W  = DP_W + K_W + OFS_W + CTL_W;
  localparam int OFS_LSB = DP_W + K_W;

  logic [CW_W-1:0]  cw_q;
  logic [PC_W-1:0]  pc_q, next_pc, link_val;
  logic             st_q, link_we;
  ag_ctl_t          ctl;
  logic [OFS_W-1:0] ofs;

  cws_prog_rom #(.PC_W(PC_W), .CW_W(CW_W), .INIT(PROG)) rom_i (
    .clk(clk), .rst(rst), .addr(pc_q), .cw_q(cw_q)
  );

  assign ctl       = ag_ctl_t'(cw_q[CW_W-1 -: CTL_W]);
  assign ofs       = cw_q[OFS_LSB +: OFS_W];
  assign dp_ctl    = cw_q[DP_W-1:0];
  assign const_val = cw_q[DP_W +: K_W];

  cws_addr_gen #(.PC_W(PC_W), .OFS_W(OFS_W)) ag_i (
    .pc_cur(pc_q), .ctl(ctl), .ofs(ofs), .status_q(st_q), .addr_in(addr_in),
    .next_pc(next_pc), .link_we(link_we), .link_val(link_val)
  );

  cws_link_reg #(.PC_W(PC_W)) lr_i (
    .clk(clk), .rst(rst), .we(link_we), .d(link_val), .q(link_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
      st_q <= 1'b0;
    end else begin
      pc_q <= next_pc;
      st_q <= status_in;
    end
  end

  assign pc = pc_q;

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (pc_q == '0 && link_addr == '0));

  p_no_jump_step_r3: assert property (@(posedge clk) disable iff (rst)
    !ctl.jen |=> pc_q == $past(pc_q) + PC_W'(1));

  p_abs_target_r5: assert property (@(posedge clk) disable iff (rst)
    (ctl.jen && ctl.cond == st_q && ctl.jkind == JK_ABS) |=> pc_q == $past(addr_in));

  p_cond_miss_r6: assert property (@(posedge clk) disable iff (rst)
    (ctl.jen && ctl.cond != st_q) |=> pc_q == $past(pc_q) + PC_W'(1));

  p_link_write_r7: assert property (@(posedge clk) disable iff (rst)
    (ctl.call && ctl.jen && ctl.cond == st_q) |=> link_addr == $past(pc_q) + PC_W'(1));

  p_link_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !(ctl.call && ctl.jen && ctl.cond == st_q) |=> $stable(link_addr));

endmodule

// File: tb/cws_sequencer_tb_top.sv
`timescale 1ns/1ps
module cws_sequencer_tb_top;

  localparam int PC_W = 5, DP_W = 8, K_W = 8, OFS_W = 4;
  localparam int CW_W = DP_W + K_W + OFS_W + 4;
  localparam int DEPTH = 1 << PC_W;
  localparam int NCYC = 4000;
  localparam logic [7:0] RET_TAG = 8'hEE;

  function automatic logic [CW_W-1:0] mk(int dp, int k, int o, bit cond, bit jt, bit jen, bit call);
    return {call, jen, jt, cond, OFS_W'(o), K_W'(k), DP_W'(dp)};
  endfunction

  function automatic logic [DEPTH*CW_W-1:0] build_prog();
    logic [DEPTH*CW_W-1:0] p;
    logic [CW_W-1:0] w;
    p = '0;
    for (int i = 0; i < DEPTH; i++) begin
      case (i)
        3:  w = mk(8'h33, 3, -3, 1, 0, 1, 0);          // backward relative
        8:  w = mk(8'h88, 8, 5, 0, 0, 1, 0);           // forward relative
        12: w = mk(8'hC2, 12, 0, 1, 1, 1, 0);          // absolute jump
        16: w = mk(8'h16, 16, 0, 0, 1, 1, 1);          // call
        20: w = mk(8'h20, RET_TAG, 0, 1, 1, 1, 0);     // return
        25: w = mk(8'h25, 25, 5, 0, 0, 0, 1);          // never jumps
        default: w = mk(i*7+1, i, 0, 0, 0, 0, 0);
      endcase
      p[i*CW_W +: CW_W] = w;
    end
    return p;
  endfunction

  localparam logic [DEPTH*CW_W-1:0] PROG = build_prog();

  logic clk = 1'b0, rst = 1'b1, status_in = 1'b0;
  logic [PC_W-1:0] addr_in = '0;
  logic [DP_W-1:0] dp_ctl;
  logic [K_W-1:0] const_val;
  logic [PC_W-1:0] pc, link_addr;

  always #2 clk = ~clk;

  cws_sequencer #(.PC_W(PC_W), .DP_W(DP_W), .K_W(K_W), .OFS_W(OFS_W), .PROG(PROG)) dut_i (
    .clk(clk), .rst(rst), .status_in(status_in), .addr_in(addr_in),
    .dp_ctl(dp_ctl), .const_val(const_val), .pc(pc), .link_addr(link_addr)
  );

  int n_chk = 0, n_fail = 0;
  int cov_back = 0, cov_call = 0, cov_ret = 0, cov_wrap = 0;
  bit done = 0;

  logic [PC_W-1:0] m_pc, m_lr;
  logic [CW_W-1:0] m_cw;
  logic m_st;
  string m_tag;

  task automatic chk(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [CW_W-1:0] word_at(logic [PC_W-1:0] a);
    return PROG[int'(a)*CW_W +: CW_W];
  endfunction

  task automatic check_outputs();
    chk(m_tag, "pc", pc, m_pc);
    chk("R2", "dp_ctl", dp_ctl, m_cw[DP_W-1:0]);
    chk("R2", "const_val", const_val, m_cw[DP_W +: K_W]);
    chk("R7", "link_addr", link_addr, m_lr);
  endtask

  task automatic check_reset();
    chk("R1", "pc", pc, 0);
    chk("R1", "dp_ctl", dp_ctl, 0);
    chk("R1", "const_val", const_val, 0);
    chk("R1", "link_addr", link_addr, 0);
  endtask

  // Drive inputs for the coming edge and advance the model across it.
  task automatic drive_model();
    bit call, jen, jt, cond, taken;
    int o;
    logic [PC_W-1:0] n_pc;
    call = m_cw[CW_W-1]; jen = m_cw[CW_W-2]; jt = m_cw[CW_W-3]; cond = m_cw[CW_W-4];
    o = int'(m_cw[DP_W+K_W +: OFS_W]);
    if (o >= (1 << (OFS_W-1))) o -= (1 << OFS_W);
    status_in = 1'($urandom_range(0, 1));
    addr_in = (m_cw[DP_W +: K_W] == RET_TAG) ? m_lr : PC_W'($urandom);
    taken = jen && (cond == m_st);
    if (!jen) m_tag = "R3";
    else if (!taken) m_tag = "R6";
    else if (jt) m_tag = "R5";
    else m_tag = "R4";
    if (taken) n_pc = jt ? addr_in : PC_W'(int'(m_pc) + o + DEPTH);
    else n_pc = PC_W'((int'(m_pc) + 1) % DEPTH);
    if (!taken && m_pc == PC_W'(DEPTH-1)) begin m_tag = "R8"; cov_wrap++; end
    if (taken && !jt && o < 0) cov_back++;
    if (taken && call) begin m_lr = m_pc + PC_W'(1); cov_call++; end
    if (taken && m_cw[DP_W +: K_W] == RET_TAG) cov_ret++;
    m_cw = word_at(m_pc);
    m_st = status_in;
    m_pc = n_pc;
  endtask

  task automatic do_reset();
    rst = 1'b1; status_in = 1'b0; addr_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset();
    m_pc = '0; m_lr = '0; m_cw = '0; m_st = 1'b0; m_tag = "R1";
    rst = 1'b0;
    drive_model();
  endtask

  initial begin
    void'($urandom(32'h5eed_c0de));
    do_reset();
    for (int c = 0; c < NCYC; c++) begin
      @(negedge clk);
      check_outputs();
      if (c == NCYC/2) do_reset();
      else drive_model();
    end
    chk("R4", "backward relative jumps taken", longint'(cov_back > 0), 1);
    chk("R7", "calls taken", longint'(cov_call > 0), 1);
    chk("R5", "returns taken", longint'(cov_ret > 0), 1);
    chk("R8", "wraps seen", longint'(cov_wrap > 0), 1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule